// File: doc/BRIEF.md
# Offset Autonull Step Controller

This block runs the null-adjust sequence for an amplifier whose input offset is trimmed by a stepped setting with 100 positions. Each adjust cycle is one high-then-low period of an adjust strobe. While the strobe is high, the amplifier runs open-loop, and the block samples the sign of its error to pick a direction. When the strobe falls, the stored setting moves one position in that direction. Repeated cycles walk the setting toward null. Because there are 100 positions, any starting point reaches null within 99 cycles.

The strobe comes from one of two sources, chosen by a parameter:

- **Internal mode:** a gated oscillator runs whole cycles for as long as the synchronized autonull request is high. At the default parameters the cycle rate is about 1 kHz, so a full null takes about 100 ms.
- **External mode:** the synchronized request is itself the strobe.

After every reset, the block can also run a power-up null of a fixed number of cycles without any request. When nulling stops, the last setting is held.

Top module: `anl_autonull`

## Requirements
- R1: While reset is asserted, and right after it, `adj_strobe_o` is low and `trim_idx_o` equals INIT_IDX (50 by default).
- R2: `trim_idx_o` stays within 0..NUM_POS-1 (0..99). A down step at 0 is ignored, and so is an up step at NUM_POS-1.
- R3: In internal mode, each adjust cycle holds the strobe high for exactly HALF_CYC clocks. During continuous running, the strobe is low for exactly HALF_CYC clocks between cycles.
- R4: The error sign is the direction: 1 steps the setting up by one and 0 steps it down by one. The sign passes through a two-stage synchronizer and is taken only while the strobe is high. A sign change that is confined to the strobe's low phase has no effect.
- R5: `trim_idx_o` changes exactly one clock after the strobe's high-to-low edge, by exactly one position. It changes at no other time.
- R6: In internal mode, cycles repeat while the request is high. Once the request is low, no new cycle starts. A high phase that is already under way completes, and its step is taken.
- R7: With POWERUP_EN set, exactly POWERUP_CYCLES (100) adjust cycles run after reset with the request low. The strobe then stays low.
- R8: With no request and no power-up sequence running, the strobe stays low and the setting is held.
- R9: In external mode, the strobe equals the request delayed by two clocks. With POWERUP_EN clear, no cycle runs without a request, and each fall of the strobe applies one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| null_req_i | input | 1 | Autonull request. In internal mode it gates the oscillator; in external mode it is the strobe. Asynchronous. |
| err_sign_i | input | 1 | Sign of the open-loop error (1 = step up). Asynchronous. |
| adj_strobe_o | output | 1 | Adjust-mode strobe |
| trim_idx_o | output | $clog2(NUM_POS) | Current setting index, 0..NUM_POS-1 |

## Verification
Each result has a fixed latency, and the bench samples at that point.

- **Setting index:** it moves exactly one clock after the strobe falls. The bench detects the fall on a falling clock edge. It checks that the old value is still present there, and checks the new value one clock later.
- **Request and sign inputs:** they take effect two clocks after they change. Sign changes are made early in a low phase, so they settle well before the next high phase. A request drop is placed where the synchronizer delay cannot let another cycle start.
- **External strobe:** its rise and fall are checked at exactly two clocks after the request edges. Strobe widths are counted clock by clock against HALF_CYC.

// File: rtl/anl_pkg.sv
package anl_pkg;

    // Strobe phase of the adjust oscillator
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Step direction latched from the error sign
    typedef enum logic {
        DIR_DN = 1'b0,
        DIR_UP = 1'b1
    } dir_e;

endpackage

// File: rtl/anl_sync.sv
module anl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/anl_osc.sv
module anl_osc
    import anl_pkg::*;
#(
    parameter int unsigned HALF_CYC = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic strobe_o
);

    localparam int unsigned CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } osc_t;

    osc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_HIGH: begin
                // a high phase always runs to its end
                if (st_q.cnt == LAST) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                if (!en_i) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LAST) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{ph: PH_LOW, cnt: '0};
        else         st_q <= st_d;
    end

    assign strobe_o = (st_q.ph == PH_HIGH);

endmodule

// File: rtl/anl_step.sv
module anl_step
    import anl_pkg::*;
#(
    parameter int unsigned NUM_POS  = 100,
    parameter int unsigned INIT_IDX = 50
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       strobe_i,
    input  logic                       sign_i,
    output logic                       step_o,
    output logic [$clog2(NUM_POS)-1:0] idx_o
);

    localparam int unsigned IW = $clog2(NUM_POS);
    localparam logic [IW-1:0] IDX_MAX  = IW'(NUM_POS - 1);
    localparam logic [IW-1:0] IDX_INIT = IW'(INIT_IDX);

    typedef struct packed {
        logic [IW-1:0] idx;
        dir_e          dir;
        logic          strobe_prev;
    } step_t;

    step_t st_d, st_q;
    logic  fall;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe_i;
        fall             = st_q.strobe_prev && !strobe_i;
        // direction follows the sign only while the strobe is high
        if (strobe_i) begin
            st_d.dir = sign_i ? DIR_UP : DIR_DN;
        end
        if (fall) begin
            if (st_q.dir == DIR_UP) begin
                if (st_q.idx != IDX_MAX) st_d.idx = st_q.idx + 1'b1;
            end else begin
                if (st_q.idx != '0)      st_d.idx = st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{idx: IDX_INIT, dir: DIR_DN, strobe_prev: 1'b0};
        else         st_q <= st_d;
    end

    assign step_o = fall;
    assign idx_o  = st_q.idx;

endmodule

// File: rtl/anl_autonull.sv
module anl_autonull #(
    parameter int unsigned NUM_POS        = 100,
    parameter int unsigned INIT_IDX       = 50,
    parameter int unsigned HALF_CYC       = 50000,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          POWERUP_EN     = 1'b1,
    parameter int unsigned POWERUP_CYCLES = 100,
    parameter bit          EXT_STROBE     = 1'b0
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       null_req_i,
    input  logic                       err_sign_i,
    output logic                       adj_strobe_o,
    output logic [$clog2(NUM_POS)-1:0] trim_idx_o
);

    localparam int unsigned PCW = $clog2(POWERUP_CYCLES + 1);
    localparam logic [PCW-1:0] PW_LAST = PCW'(POWERUP_CYCLES - 1);

    typedef struct packed {
        logic           active;
        logic [PCW-1:0] cnt;
    } pwr_t;

    logic req_s, sign_s, osc_en, osc_strobe, strobe, step;
    pwr_t pwr_d, pwr_q;

    anl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(null_req_i), .q_o(req_s)
    );

    anl_sync #(.STAGES(SYNC_STAGES)) u_sign_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(err_sign_i), .q_o(sign_s)
    );

    // Power-up sequence: counts completed cycles, then hands back to the request
    always_comb begin
        pwr_d = pwr_q;
        if (pwr_q.active && step) begin
            if (pwr_q.cnt == PW_LAST) begin
                pwr_d.active = 1'b0;
                pwr_d.cnt    = '0;
            end else begin
                pwr_d.cnt = pwr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pwr_q <= '{active: POWERUP_EN, cnt: '0};
        else         pwr_q <= pwr_d;
    end

    generate
        if (EXT_STROBE) begin : g_ext
            assign osc_en = pwr_q.active;
            assign strobe = pwr_q.active ? osc_strobe : req_s;
        end else begin : g_int
            assign osc_en = pwr_q.active || req_s;
            assign strobe = osc_strobe;
        end
    endgenerate

    anl_osc #(.HALF_CYC(HALF_CYC)) u_osc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (osc_en),
        .strobe_o(osc_strobe)
    );

    anl_step #(.NUM_POS(NUM_POS), .INIT_IDX(INIT_IDX)) u_step (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(strobe),
        .sign_i  (sign_s),
        .step_o  (step),
        .idx_o   (trim_idx_o)
    );

    assign adj_strobe_o = strobe;

endmodule

// File: rtl/anl_autonull_chk.sv
module anl_autonull_chk #(
    parameter int unsigned NUM_POS    = 100,
    parameter int unsigned HALF_CYC   = 50000,
    parameter bit          EXT_STROBE = 1'b0
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       strobe_i,
    input logic [$clog2(NUM_POS)-1:0] idx_i
);

    logic [31:0] hi_cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       hi_cnt_q <= '0;
        else if (strobe_i) hi_cnt_q <= hi_cnt_q + 1;
        else               hi_cnt_q <= '0;
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_i <= ($clog2(NUM_POS))'(NUM_POS - 1)); // R2

    AST_CHANGE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx_i != $past(idx_i)) |-> (!$past(strobe_i) && $past(strobe_i, 2))); // R5

    AST_STEP_OF_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx_i != $past(idx_i)) |->
        ((idx_i == $past(idx_i) + 1'b1) || (idx_i + 1'b1 == $past(idx_i)))); // R5

    AST_FALL_MOVES_OR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(strobe_i) |=> ((idx_i != $past(idx_i)) || (idx_i == '0) ||
                             (idx_i == ($clog2(NUM_POS))'(NUM_POS - 1)))); // R2

    generate
        if (!EXT_STROBE) begin : g_width
            AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(strobe_i) |-> (hi_cnt_q == HALF_CYC)); // R3
        end
    endgenerate

endmodule

bind anl_autonull anl_autonull_chk #(
    .NUM_POS   (NUM_POS),
    .HALF_CYC  (HALF_CYC),
    .EXT_STROBE(EXT_STROBE)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(adj_strobe_o),
    .idx_i   (trim_idx_o)
);

// File: tb/anl_autonull_tb.sv
module anl_autonull_tb_top;

    localparam int HALF = 6;
    localparam int NPOS = 100;
    localparam int PWC  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, sign = 1'b0;
    logic req_e = 1'b0, sign_e = 1'b0;
    logic strobe, strobe_e;
    logic [6:0] idx, idx_e;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_idx = 50;

    always #5 clk = ~clk;

    anl_autonull #(.HALF_CYC(HALF), .POWERUP_CYCLES(PWC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .null_req_i(req), .err_sign_i(sign),
        .adj_strobe_o(strobe), .trim_idx_o(idx)
    );

    anl_autonull #(.HALF_CYC(HALF), .POWERUP_EN(1'b0), .EXT_STROBE(1'b1)) dut_ext_i (
        .clk_i(clk), .rst_ni(rst_n), .null_req_i(req_e), .err_sign_i(sign_e),
        .adj_strobe_o(strobe_e), .trim_idx_o(idx_e)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int next_idx(input int cur, input logic up);
        if (up) return (cur == NPOS - 1) ? cur : cur + 1;
        return (cur == 0) ? cur : cur - 1;
    endfunction

    // at the negedge where the strobe is first seen low: old value, then new one clock later
    task automatic finish_fall(input string tag);
        chk({tag, " R5 old index at fall"}, int'(idx), exp_idx);
        exp_idx = next_idx(exp_idx, sign);
        @(negedge clk);
        chk({tag, " R5 index one clock after fall"}, int'(idx), exp_idx);
    endtask

    task automatic step_once(input string tag);
        logic p;
        p = strobe;
        @(negedge clk);
        while (!(p && !strobe)) begin
            p = strobe;
            @(negedge clk);
        end
        finish_fall(tag);
    endtask

    task automatic idle_check(input string tag, input int n);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (strobe) highs++;
        end
        chk({tag, " R8 strobe stays low"}, highs, 0);
        chk({tag, " R8 index held"}, int'(idx), exp_idx);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1 strobe low in reset", int'(strobe), 0);
        chk("R1 index init in reset", int'(idx), 50);
        chk("R1 ext index init in reset", int'(idx_e), 50);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe low after reset", int'(strobe), 0);
    endtask

    task automatic t_powerup();
        for (int i = 0; i < PWC; i++) step_once("R7 power-up");
        chk("R2 saturated at 0 after power-up", int'(idx), 0);
        idle_check("R7 after power-up", 40);
    endtask

    task automatic t_up_run();
        sign = 1'b1;
        repeat (4) @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < 12; i++) step_once("R4 up run");
        req = 1'b0;
        chk("R4 up run total", int'(idx), 12);
        idle_check("R6 after request drop", 30);
    endtask

    task automatic t_direction();
        sign = 1'b0;
        repeat (4) @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < 3; i++) step_once("R4 down");
        chk("R4 after three down", int'(idx), 9);
        sign = 1'b1;
        for (int i = 0; i < 5; i++) step_once("R4 up");
        chk("R4 after five up", int'(idx), 14);
        sign = 1'b0;
        step_once("R4 down before glitch");
        // one-clock sign pulse inside the low phase must not change direction
        sign = 1'b1;
        @(negedge clk);
        sign = 1'b0;
        step_once("R4 low-phase sign pulse ignored");
        chk("R4 glitch ignored total", int'(idx), 12);
        req = 1'b0;
        idle_check("R6 direction end", 30);
    endtask

    task automatic t_period();
        int lc, hc;
        sign = 1'b1;
        repeat (4) @(negedge clk);
        req = 1'b1;
        step_once("R3 first");
        lc = 1;
        while (!strobe) begin
            lc++;
            @(negedge clk);
        end
        hc = 0;
        while (strobe) begin
            hc++;
            @(negedge clk);
        end
        chk("R3 low width", lc, HALF);
        chk("R3 high width", hc, HALF);
        finish_fall("R3 second");
        req = 1'b0;
        idle_check("R6 period end", 30);
    endtask

    task automatic t_sat_high();
        sign = 1'b1;
        repeat (4) @(negedge clk);
        req = 1'b1;
        for (int i = 0; i < 90; i++) step_once("R2 up to top");
        chk("R2 saturated at 99", int'(idx), 99);
        req = 1'b0;
        idle_check("R2 top hold", 30);
    endtask

    task automatic t_drop_mid_high();
        int hc;
        sign = 1'b0;
        repeat (4) @(negedge clk);
        req = 1'b1;
        while (!strobe) @(negedge clk);
        req = 1'b0;
        hc = 0;
        while (strobe) begin
            hc++;
            @(negedge clk);
        end
        chk("R6 high phase completes after drop", hc, HALF);
        finish_fall("R6 step after drop");
        chk("R6 index after drop", int'(idx), 98);
        idle_check("R6 no new cycle", 40);
    endtask

    task automatic t_external();
        int hc = 0;
        int first = 0;
        chk("R9 no strobe without request", int'(strobe_e), 0);
        sign_e = 1'b1;
        repeat (4) @(negedge clk);
        req_e = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (strobe_e) begin
                hc++;
                if (first == 0) first = i;
            end
            if (i == 5) req_e = 1'b0;
            if (i == 7) chk("R9 ext index old at fall", int'(idx_e), 50);
            if (i == 8) chk("R9 ext index after fall", int'(idx_e), 51);
        end
        chk("R9 ext strobe delay", first, 2);
        chk("R9 ext strobe width", hc, 5);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_up_run();
        t_direction();
        t_period();
        t_sat_high();
        t_drop_mid_high();
        t_external();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule